// File: doc/BRIEF.md
# Host Cycle Address Decoder

This block decides, for every cycle the host processor starts, which single destination receives it: the graphics port, the local configuration registers, main memory, or the downstream hub link. Named targets claim a cycle when its address falls in one of their ranges. A cycle that no target claims goes to the hub link by default.

I/O cycles are looked up against a fixed configuration-access range and a programmable graphics I/O window. Memory cycles are looked up against a set of programmable graphics memory windows, then against two system-management regions, then against the top-of-memory boundary. The first system-management region is the legacy block at 0xA0000–0xBFFFF. The second is a carve-out of selectable size placed directly under the top of memory. A memory cycle that hits either region while the region is active goes to memory and raises a flag.

The decision, the flag and a copy of the address are registered, so each one appears one clock after the cycle's valid strobe.

Top module: `host_route_decoder`

## Requirements
- R1: While reset is held, and after it is released until the first valid cycle, `dst_sel`, `smm_hit` and `addr_q` are all zero.
- R2: A cycle presented with `cyc_valid` high is reflected on the outputs on the next clock edge, with exactly one bit of `dst_sel` set. In a clock where `cyc_valid` was low, `dst_sel` and `smm_hit` are zero and `addr_q` keeps its last captured value.
- R3: The destination bits are: `dst_sel[0]` graphics port, `dst_sel[1]` configuration space, `dst_sel[2]` main memory, `dst_sel[3]` hub link.
- R4: For an I/O cycle (`cyc_is_io`=1), an address from 0xCF8 to 0xCFF (both ends included) selects configuration space. Otherwise, an address inside the graphics I/O window [base, limit] selects the graphics port. Otherwise the cycle goes to the hub link. An I/O cycle never selects main memory.
- R5: For a memory cycle, an address inside any enabled graphics memory window (base ≤ address ≤ limit) selects the graphics port. This check takes priority over every other memory rule, the system-management regions included. A window whose limit is below its base is disabled.
- R6: A memory cycle that matches no rule of R5, R7 or R8 selects main memory when the address is below `top_of_mem`, and the hub link when the address is at or above it. A memory cycle never selects configuration space.
- R7: A memory cycle to 0xA0000–0xBFFFF that no graphics window claims goes to main memory with `smm_hit`=1 when `smram_en`=1. When `smram_en`=0 it goes to the hub link with `smm_hit`=0.
- R8: When `tseg_en`=1, memory addresses from `top_of_mem` − size up to `top_of_mem` − 1 go to main memory with `smm_hit`=1. The size is set by `tseg_sel`: 00 gives 128 KB, 01 gives 256 KB, 10 gives 512 KB and 11 gives 1 MB.
- R9: The carve-out of R8 is active only when `top_of_mem` − size is at least 0x1000_0000 (256 MB). Otherwise those addresses are ordinary memory with `smm_hit`=0.
- R10: `smm_hit` is set only together with `dst_sel[2]`, and only for memory cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | Host cycle present this clock |
| cyc_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_addr | input | 32 | Host cycle address |
| gfx_mem_base | input | 64 | Graphics memory window bases, window k at bits [32k+31:32k] |
| gfx_mem_limit | input | 64 | Graphics memory window limits (inclusive), same packing |
| gfx_io_base | input | 32 | Graphics I/O window base |
| gfx_io_limit | input | 32 | Graphics I/O window limit (inclusive) |
| top_of_mem | input | 32 | First address above installed memory |
| smram_en | input | 1 | Enables remapping of the legacy system-management block |
| tseg_en | input | 1 | Enables the carve-out under top of memory |
| tseg_sel | input | 2 | Carve-out size select |
| dst_sel | output | 4 | One-hot destination, registered |
| addr_q | output | 32 | Registered address of the last valid cycle |
| smm_hit | output | 1 | Registered system-management region flag |

## Verification
A wrong priority or a wrong range edge shows up on `dst_sel` one clock after the strobe for the offending cycle. So the bench places addresses on both sides of every boundary: window ends, the configuration range, the legacy block, the carve-out floor and top of memory. A wrong carve-out size or floor is seen as a wrong `smm_hit` on the address just below the expected lower bound, again after one clock. Stale state in the output registers would appear as a nonzero `dst_sel` or a moved `addr_q` in the idle clock after each cycle.

// File: rtl/hrd_pkg.sv
package hrd_pkg;
  localparam int HRD_AW  = 32;
  localparam int NUM_DST = 4;

  localparam int DST_GFX = 0;
  localparam int DST_CFG = 1;
  localparam int DST_MEM = 2;
  localparam int DST_HUB = 3;

  typedef logic [HRD_AW-1:0]  addr_t;
  typedef logic [NUM_DST-1:0] dst_vec_t;

  // Inclusive range test; an empty range (limit below base) never matches.
  function automatic logic in_window(addr_t a, addr_t base, addr_t limit);
    return (limit >= base) && (a >= base) && (a <= limit);
  endfunction

  // Carve-out size: smallest unit doubled once per select step.
  function automatic addr_t carve_span(addr_t unit_bytes, logic [1:0] sel);
    return unit_bytes << sel;
  endfunction

  function automatic dst_vec_t dst_bit(int idx);
    dst_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/hrd_window_cmp.sv
module hrd_window_cmp
  import hrd_pkg::*;
(
  input  addr_t addr,
  input  addr_t base,
  input  addr_t limit,
  output logic  hit
);
  always_comb hit = in_window(addr, base, limit);
endmodule

// File: rtl/hrd_smm_region.sv
module hrd_smm_region
  import hrd_pkg::*;
#(
  parameter addr_t LEGACY_LO  = 32'h000A_0000,
  parameter addr_t LEGACY_HI  = 32'h000B_FFFF,
  parameter addr_t EXT_FLOOR  = 32'h1000_0000,
  parameter addr_t CARVE_UNIT = 32'h0002_0000
) (
  input  addr_t      addr,
  input  addr_t      top_of_mem,
  input  logic       tseg_en,
  input  logic [1:0] tseg_sel,
  output logic       legacy_hit,
  output logic       tseg_hit,
  output logic       tseg_active
);
  addr_t span;
  addr_t carve_lo;
  logic  fits;

  always_comb begin
    span        = carve_span(CARVE_UNIT, tseg_sel);
    fits        = (top_of_mem >= span);
    carve_lo    = top_of_mem - span;
    tseg_active = tseg_en && fits && (carve_lo >= EXT_FLOOR);
    tseg_hit    = tseg_active && (addr >= carve_lo) && (addr < top_of_mem);
    legacy_hit  = (addr >= LEGACY_LO) && (addr <= LEGACY_HI);
  end
endmodule

// File: rtl/hrd_route_sel.sv
module hrd_route_sel
  import hrd_pkg::*;
(
  input  logic     is_io,
  input  logic     cfg_hit,
  input  logic     gfx_io_hit,
  input  logic     gfx_mem_hit,
  input  logic     legacy_hit,
  input  logic     smram_en,
  input  logic     tseg_hit,
  input  logic     below_tom,
  output dst_vec_t dst,
  output logic     smm
);
  always_comb begin
    dst = dst_bit(DST_HUB);
    smm = 1'b0;
    if (is_io) begin
      if (cfg_hit)         dst = dst_bit(DST_CFG);
      else if (gfx_io_hit) dst = dst_bit(DST_GFX);
    end else begin
      if (gfx_mem_hit) begin
        dst = dst_bit(DST_GFX);
      end else if (legacy_hit) begin
        if (smram_en) begin
          dst = dst_bit(DST_MEM);
          smm = 1'b1;
        end
      end else if (tseg_hit) begin
        dst = dst_bit(DST_MEM);
        smm = 1'b1;
      end else if (below_tom) begin
        dst = dst_bit(DST_MEM);
      end
    end
  end
endmodule

// File: rtl/host_route_decoder.sv
module host_route_decoder
  import hrd_pkg::*;
#(
  parameter int    NUM_GFX_WIN = 2,
  parameter addr_t CFG_IO_BASE = 32'h0000_0CF8,
  parameter int    CFG_IO_SPAN = 8,
  parameter addr_t EXT_FLOOR   = 32'h1000_0000,
  parameter addr_t CARVE_UNIT  = 32'h0002_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cyc_valid,
  input  logic                        cyc_is_io,
  input  logic [HRD_AW-1:0]           cyc_addr,
  input  logic [NUM_GFX_WIN*HRD_AW-1:0] gfx_mem_base,
  input  logic [NUM_GFX_WIN*HRD_AW-1:0] gfx_mem_limit,
  input  logic [HRD_AW-1:0]           gfx_io_base,
  input  logic [HRD_AW-1:0]           gfx_io_limit,
  input  logic [HRD_AW-1:0]           top_of_mem,
  input  logic                        smram_en,
  input  logic                        tseg_en,
  input  logic [1:0]                  tseg_sel,
  output logic [NUM_DST-1:0]          dst_sel,
  output logic [HRD_AW-1:0]           addr_q,
  output logic                        smm_hit
);
  localparam addr_t CFG_IO_LAST = CFG_IO_BASE + addr_t'(CFG_IO_SPAN - 1);

  // Named decode events, visible to the assertions below.
  logic [NUM_GFX_WIN-1:0] win_hit;
  logic     gfx_mem_hit;
  logic     gfx_io_hit;
  logic     cfg_hit;
  logic     legacy_hit;
  logic     tseg_hit;
  logic     tseg_active;
  logic     below_tom;
  dst_vec_t dst_d;
  logic     smm_d;

  for (genvar w = 0; w < NUM_GFX_WIN; w++) begin : g_win
    hrd_window_cmp u_cmp (
      .addr  (cyc_addr),
      .base  (gfx_mem_base [w*HRD_AW +: HRD_AW]),
      .limit (gfx_mem_limit[w*HRD_AW +: HRD_AW]),
      .hit   (win_hit[w])
    );
  end

  hrd_window_cmp u_io_cmp (
    .addr  (cyc_addr),
    .base  (gfx_io_base),
    .limit (gfx_io_limit),
    .hit   (gfx_io_hit)
  );

  hrd_smm_region #(
    .EXT_FLOOR  (EXT_FLOOR),
    .CARVE_UNIT (CARVE_UNIT)
  ) u_smm (
    .addr        (cyc_addr),
    .top_of_mem  (top_of_mem),
    .tseg_en     (tseg_en),
    .tseg_sel    (tseg_sel),
    .legacy_hit  (legacy_hit),
    .tseg_hit    (tseg_hit),
    .tseg_active (tseg_active)
  );

  always_comb begin
    gfx_mem_hit = |win_hit;
    cfg_hit     = (cyc_addr >= CFG_IO_BASE) && (cyc_addr <= CFG_IO_LAST);
    below_tom   = (cyc_addr < top_of_mem);
  end

  hrd_route_sel u_sel (
    .is_io       (cyc_is_io),
    .cfg_hit     (cfg_hit),
    .gfx_io_hit  (gfx_io_hit),
    .gfx_mem_hit (gfx_mem_hit),
    .legacy_hit  (legacy_hit),
    .smram_en    (smram_en),
    .tseg_hit    (tseg_hit),
    .below_tom   (below_tom),
    .dst         (dst_d),
    .smm         (smm_d)
  );

  logic vld_q;
  logic io_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      io_q    <= 1'b0;
      dst_sel <= '0;
      smm_hit <= 1'b0;
      addr_q  <= '0;
    end else begin
      vld_q <= cyc_valid;
      if (cyc_valid) begin
        io_q    <= cyc_is_io;
        dst_sel <= dst_d;
        smm_hit <= smm_d;
        addr_q  <= cyc_addr;
      end else begin
        dst_sel <= '0;
        smm_hit <= 1'b0;
      end
    end
  end

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($countones(dst_sel) == 1)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> (dst_sel == '0 && !smm_hit)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(addr_q)); // R2
  AST_IO_NEVER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && io_q) |-> !dst_sel[DST_MEM]); // R4
  AST_MEM_NEVER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !io_q) |-> !dst_sel[DST_CFG]); // R6
  AST_SMM_ONLY_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    smm_hit |-> (dst_sel[DST_MEM] && !io_q)); // R10
  AST_TSEG_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    tseg_hit |-> (cyc_addr >= EXT_FLOOR && tseg_active)); // R9
endmodule

// File: tb/host_route_decoder_test.sv
module host_route_decoder_test;
  localparam logic [3:0] D_GFX = 4'b0001;
  localparam logic [3:0] D_CFG = 4'b0010;
  localparam logic [3:0] D_MEM = 4'b0100;
  localparam logic [3:0] D_HUB = 4'b1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic        cyc_is_io = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic [63:0] gfx_mem_base;
  logic [63:0] gfx_mem_limit;
  logic [31:0] gfx_io_base = 32'h3B0;
  logic [31:0] gfx_io_limit = 32'h3DF;
  logic [31:0] top_of_mem = 32'h2000_0000;
  logic        smram_en = 1'b0;
  logic        tseg_en = 1'b0;
  logic [1:0]  tseg_sel = 2'b00;
  logic [3:0]  dst_sel;
  logic [31:0] addr_q;
  logic        smm_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  host_route_decoder uut (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_is_io(cyc_is_io),
    .cyc_addr(cyc_addr), .gfx_mem_base(gfx_mem_base), .gfx_mem_limit(gfx_mem_limit),
    .gfx_io_base(gfx_io_base), .gfx_io_limit(gfx_io_limit), .top_of_mem(top_of_mem),
    .smram_en(smram_en), .tseg_en(tseg_en), .tseg_sel(tseg_sel),
    .dst_sel(dst_sel), .addr_q(addr_q), .smm_hit(smm_hit)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Present one cycle, then sample at the falling edge after the capturing edge.
  task automatic issue(logic io, logic [31:0] a);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_is_io = io; cyc_addr = a;
    @(negedge clk);
    cyc_valid = 1'b0;
  endtask

  task automatic expect_route(string tag, logic io, logic [31:0] a,
                              logic [3:0] d, logic s);
    issue(io, a);
    chk({tag, " dst"}, {28'h0, dst_sel}, {28'h0, d});
    chk({tag, " smm"}, {31'h0, smm_hit}, {31'h0, s});
  endtask

  task automatic t_reset();
    chk("R1 dst", {28'h0, dst_sel}, 32'h0);
    chk("R1 smm", {31'h0, smm_hit}, 32'h0);
    chk("R1 addr", addr_q, 32'h0);
  endtask

  task automatic t_io();
    expect_route("R4 cfg lo", 1, 32'hCF8, D_CFG, 0);
    expect_route("R4 cfg hi", 1, 32'hCFF, D_CFG, 0);
    expect_route("R4 past cfg", 1, 32'hD00, D_HUB, 0);
    expect_route("R4 below cfg", 1, 32'hCF7, D_HUB, 0);
    expect_route("R4 gfx lo", 1, 32'h3B0, D_GFX, 0);
    expect_route("R4 gfx hi", 1, 32'h3DF, D_GFX, 0);
    expect_route("R4 past gfx", 1, 32'h3E0, D_HUB, 0);
    expect_route("R4 no mem", 1, 32'h1000, D_HUB, 0);
  endtask

  task automatic t_mem_basic();
    expect_route("R5 win lo", 0, 32'hE000_0000, D_GFX, 0);
    expect_route("R5 win hi", 0, 32'hEFFF_FFFF, D_GFX, 0);
    expect_route("R6 above win", 0, 32'hF000_0000, D_HUB, 0);
    expect_route("R6 low mem", 0, 32'h0000_1000, D_MEM, 0);
    expect_route("R6 no cfg", 0, 32'h0000_0CF8, D_MEM, 0);
    expect_route("R6 tom-1", 0, 32'h1FFF_FFFF, D_MEM, 0);
    expect_route("R6 tom", 0, 32'h2000_0000, D_HUB, 0);
    expect_route("R3 gfx bit", 0, 32'hE800_0000, D_GFX, 0);
  endtask

  task automatic t_idle();
    issue(0, 32'h0000_4000);
    @(negedge clk);
    chk("R2 idle dst", {28'h0, dst_sel}, 32'h0);
    chk("R2 idle smm", {31'h0, smm_hit}, 32'h0);
    chk("R2 addr hold", addr_q, 32'h0000_4000);
  endtask

  task automatic t_legacy();
    smram_en = 1'b0;
    expect_route("R7 off", 0, 32'h000A_0000, D_HUB, 0);
    smram_en = 1'b1;
    expect_route("R7 lo", 0, 32'h000A_0000, D_MEM, 1);
    expect_route("R7 hi", 0, 32'h000B_FFFF, D_MEM, 1);
    expect_route("R7 above", 0, 32'h000C_0000, D_MEM, 0);
    expect_route("R7 below", 0, 32'h0009_FFFF, D_MEM, 0);
    expect_route("R10 io legacy", 1, 32'h000A_0000, D_HUB, 0);
    gfx_mem_base[63:32]  = 32'h000A_0000;
    gfx_mem_limit[63:32] = 32'h000A_FFFF;
    expect_route("R5 over legacy", 0, 32'h000A_8000, D_GFX, 0);
    expect_route("R7 rest", 0, 32'h000B_0000, D_MEM, 1);
    gfx_mem_base[63:32]  = 32'hFFFF_0000;
    gfx_mem_limit[63:32] = 32'h0000_0000;
  endtask

  task automatic t_tseg();
    tseg_en = 1'b1; tseg_sel = 2'b00;
    expect_route("R8 128K lo", 0, 32'h1FFE_0000, D_MEM, 1);
    expect_route("R8 128K below", 0, 32'h1FFD_FFFF, D_MEM, 0);
    expect_route("R8 top", 0, 32'h1FFF_FFFF, D_MEM, 1);
    tseg_sel = 2'b10;
    expect_route("R8 512K lo", 0, 32'h1FF8_0000, D_MEM, 1);
    tseg_sel = 2'b11;
    expect_route("R8 1M lo", 0, 32'h1FF0_0000, D_MEM, 1);
    expect_route("R8 1M below", 0, 32'h1FEF_FFFF, D_MEM, 0);
    top_of_mem = 32'h1008_0000;
    expect_route("R9 floor off", 0, 32'h1007_FFFF, D_MEM, 0);
    tseg_sel = 2'b01;
    expect_route("R9 floor ok", 0, 32'h1004_0000, D_MEM, 1);
    expect_route("R9 floor below", 0, 32'h1003_FFFF, D_MEM, 0);
    tseg_en = 1'b0;
    expect_route("R8 disabled", 0, 32'h1004_0000, D_MEM, 0);
    top_of_mem = 32'h2000_0000;
  endtask

  task automatic t_win_disable();
    gfx_mem_limit[31:0] = 32'hD000_0000;
    expect_route("R5 disabled", 0, 32'hE000_0000, D_HUB, 0);
    gfx_mem_limit[31:0] = 32'hEFFF_FFFF;
  endtask

  initial begin
    gfx_mem_base  = {32'hFFFF_0000, 32'hE000_0000};
    gfx_mem_limit = {32'h0000_0000, 32'hEFFF_FFFF};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_io();
    t_mem_basic();
    t_idle();
    t_legacy();
    t_tseg();
    t_win_disable();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule